// File: doc/BRIEF.md
# Automatic Remote Loopback Controller

This block sits beside a line interface and watches the recovered receive bit stream for a repeating "loop-up" code. Each recovered bit comes with a strobe and is taken as a mark when either receive rail is high. Software programs the loop-up and loop-down codes, each as two 8-bit halves plus a length field. When the loop-up code has been present without a break for a programmable number of timebase ticks, the block switches the line interface into remote loopback and raises a status flag. It leaves loopback only after the loop-down code has been present without a break for the same number of ticks.

In remote loopback the transmit rails are driven from the recovered receive rails, and the local transmit inputs are ignored. The receive rails are always passed through to the receive outputs. A manual loopback bit is ORed with the automatic state. Clearing the enable bit resets the automatic machinery at once. The tick count is a parameter, so a 5-second qualification can be built from any timebase.

Top module: `rlb_auto_ctrl`

## Requirements
- R1: A code is the top LEN bits of {hi,lo}, with bit 15 sent first. LEN 1..16 is used as given, and LEN 0 or above 16 means 16. The detector reports a match only when at least 32 bits have been strobed since enable, and the newest 32 bits (a bit is rx_pos|rx_neg at rx_stb) equal the code repeated end to end, at some phase, with at most the tolerated number of mismatches.
- R2: From idle, arl_stat rises only after the loop-up match has held without a break through QUAL_TICKS tick pulses. It rises on the clock edge that samples the last of those ticks.
- R3: Any cycle without a match during qualification restarts the tick count from zero.
- R4: While in loopback, arl_stat clears only after the loop-down match has held through QUAL_TICKS tick pulses, and a break restarts that count.
- R5: The loop-down code has no effect while idle, and the loop-up code has no effect while in loopback.
- R6: While arl_en is low, including the edge after it falls, the state, the counter, the fill count and arl_stat return to idle/zero, and no automatic loopback occurs.
- R7: rlb_sel is high whenever arl_stat or man_rlb is high, and low otherwise.
- R8: When rlb_sel is high, {tx_pos_o,tx_neg_o} equals {rx_pos,rx_neg}; otherwise it equals {tx_pos_i,tx_neg_i}. {rxo_pos,rxo_neg} always equals {rx_pos,rx_neg}.
- R9: One mismatched bit in the 32-bit window still counts as a match; two or more do not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arl_en | input | 1 | Automatic loopback enable; low resets the automatic logic |
| man_rlb | input | 1 | Manual remote loopback request |
| tick | input | 1 | Timebase pulse used for qualification |
| rx_stb | input | 1 | Recovered bit strobe |
| rx_pos | input | 1 | Recovered positive rail |
| rx_neg | input | 1 | Recovered negative rail |
| up_hi | input | 8 | Loop-up code, upper half |
| up_lo | input | 8 | Loop-up code, lower half |
| up_len | input | 5 | Loop-up code length |
| dn_hi | input | 8 | Loop-down code, upper half |
| dn_lo | input | 8 | Loop-down code, lower half |
| dn_len | input | 5 | Loop-down code length |
| tx_pos_i | input | 1 | Local transmit positive rail |
| tx_neg_i | input | 1 | Local transmit negative rail |
| tx_pos_o | output | 1 | Transmit positive rail to line |
| tx_neg_o | output | 1 | Transmit negative rail to line |
| rxo_pos | output | 1 | Receive positive rail out |
| rxo_neg | output | 1 | Receive negative rail out |
| rlb_sel | output | 1 | Effective remote loopback select |
| arl_stat | output | 1 | Automatic loopback active flag |

## Verification
The bench goes after a break in the pattern partway through qualification. A design that kept counting instead of restarting would enter loopback about two ticks early. It checks the mismatch boundary: one flipped bit per window must still qualify, and a design with zero tolerance would never enter loopback in that case. Three flipped bits must fail, and a design that tolerated them would loop. It sends the opposite code in each state; a design that did not switch the detector's code with the state would leave or enter loopback on the wrong pattern. It also drops the enable mid-loopback and drives length values 0 and 20. A design that ignored the enable would keep transmitting received data, and one that failed to clamp the length would fail to detect a full 16-bit code.

// File: rtl/rlb_pkg.sv
`timescale 1ns/1ps
package rlb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_QUAL_UP = 2'd1,
    ST_LOOPED  = 2'd2,
    ST_QUAL_DN = 2'd3
  } rlb_state_e;

  // Loopback is held in both the looped state and while qualifying the exit
  function automatic logic state_is_looped(input rlb_state_e s);
    return (s == ST_LOOPED) || (s == ST_QUAL_DN);
  endfunction

endpackage

// File: rtl/rlb_pattern_det.sv
`timescale 1ns/1ps
module rlb_pattern_det #(
  parameter int WIN     = 32,
  parameter int CW      = 16,
  parameter int MAX_ERR = 1,
  parameter int LEN_W   = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             bit_stb,
  input  logic             bit_in,
  input  logic [CW-1:0]    code,
  input  logic [LEN_W-1:0] len_raw,
  output logic             match,
  output logic             full
);

  localparam int FILL_W = $clog2(WIN + 1);

  logic [WIN-1:0]    win_q;
  logic [FILL_W-1:0] fill_q;
  logic [CW-1:0]     ph_ok;
  int unsigned       len_eff;

  // Length 0 or anything beyond the code width selects the full width
  function automatic int unsigned clamp_len(input logic [LEN_W-1:0] l);
    if (l == '0 || int'(l) > CW) return CW;
    return int'(l);
  endfunction

  // Expected window for a given phase: bit i is the bit received i strobes ago,
  // the newest bit sits at pattern index ph, older bits walk backwards cyclically
  function automatic logic [WIN-1:0] ref_window(input logic [CW-1:0] c,
                                                input int unsigned len,
                                                input int unsigned ph);
    logic [WIN-1:0] r;
    int unsigned idx;
    idx = ph;
    for (int i = 0; i < WIN; i++) begin
      r[i] = c[CW-1-idx];
      idx  = (idx == 0) ? len - 1 : idx - 1;
    end
    return r;
  endfunction

  always_comb len_eff = clamp_len(len_raw);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= '0;
    end else if (bit_stb) begin
      win_q <= {win_q[WIN-2:0], bit_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q <= '0;
    end else if (!en) begin
      fill_q <= '0;
    end else if (bit_stb && fill_q != FILL_W'(WIN)) begin
      fill_q <= fill_q + 1'b1;
    end
  end

  for (genvar ph = 0; ph < CW; ph++) begin : g_phase
    assign ph_ok[ph] = (ph < len_eff) &&
                       ($countones(win_q ^ ref_window(code, len_eff, ph)) <= MAX_ERR);
  end

  assign full  = (fill_q == FILL_W'(WIN));
  assign match = full && (|ph_ok);

endmodule

// File: rtl/rlb_qual_fsm.sv
`timescale 1ns/1ps
module rlb_qual_fsm
  import rlb_pkg::*;
#(
  parameter int QUAL_TICKS = 5000,
  parameter int CNT_W      = (QUAL_TICKS > 1) ? $clog2(QUAL_TICKS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tick,
  input  logic             match,
  output rlb_state_e       state,
  output logic [CNT_W-1:0] cnt,
  output logic             looped
);

  rlb_state_e       st_q;
  logic [CNT_W-1:0] cnt_q;
  logic             at_last;

  assign at_last = (cnt_q == CNT_W'(QUAL_TICKS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else if (!en) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (match) begin
            st_q  <= ST_QUAL_UP;
            cnt_q <= '0;
          end
        end
        ST_QUAL_UP: begin
          if (!match) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
          end else if (tick) begin
            if (at_last) begin
              st_q  <= ST_LOOPED;
              cnt_q <= '0;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        ST_LOOPED: begin
          if (match) begin
            st_q  <= ST_QUAL_DN;
            cnt_q <= '0;
          end
        end
        ST_QUAL_DN: begin
          if (!match) begin
            st_q  <= ST_LOOPED;
            cnt_q <= '0;
          end else if (tick) begin
            if (at_last) begin
              st_q  <= ST_IDLE;
              cnt_q <= '0;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        default: begin
          st_q  <= ST_IDLE;
          cnt_q <= '0;
        end
      endcase
    end
  end

  assign state  = st_q;
  assign cnt    = cnt_q;
  assign looped = state_is_looped(st_q);

endmodule

// File: rtl/rlb_tx_mux.sv
`timescale 1ns/1ps
module rlb_tx_mux #(
  parameter int RAILS = 2
) (
  input  logic             sel,
  input  logic [RAILS-1:0] rx_rails,
  input  logic [RAILS-1:0] tx_rails,
  output logic [RAILS-1:0] line_rails
);

  for (genvar r = 0; r < RAILS; r++) begin : g_rail
    assign line_rails[r] = sel ? rx_rails[r] : tx_rails[r];
  end

endmodule

// File: rtl/rlb_auto_ctrl.sv
`timescale 1ns/1ps
module rlb_auto_ctrl
  import rlb_pkg::*;
#(
  parameter int QUAL_TICKS = 5000,
  parameter int WIN        = 32,
  parameter int MAX_ERR    = 1,
  parameter int REG_W      = 8,
  parameter int LEN_W      = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arl_en,
  input  logic             man_rlb,
  input  logic             tick,
  input  logic             rx_stb,
  input  logic             rx_pos,
  input  logic             rx_neg,
  input  logic [REG_W-1:0] up_hi,
  input  logic [REG_W-1:0] up_lo,
  input  logic [LEN_W-1:0] up_len,
  input  logic [REG_W-1:0] dn_hi,
  input  logic [REG_W-1:0] dn_lo,
  input  logic [LEN_W-1:0] dn_len,
  input  logic             tx_pos_i,
  input  logic             tx_neg_i,
  output logic             tx_pos_o,
  output logic             tx_neg_o,
  output logic             rxo_pos,
  output logic             rxo_neg,
  output logic             rlb_sel,
  output logic             arl_stat
);

  localparam int CW    = 2 * REG_W;
  localparam int CNT_W = (QUAL_TICKS > 1) ? $clog2(QUAL_TICKS) : 1;

  logic             en_q;
  logic             en_fall;
  logic             rx_bit;
  logic [CW-1:0]    act_code;
  logic [LEN_W-1:0] act_len;
  logic             det_match;
  logic             det_full;
  rlb_state_e       fsm_state;
  logic [CNT_W-1:0] qual_cnt;
  logic             auto_looped;
  logic [1:0]       line_rails;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= arl_en;
  end

  assign en_fall = en_q & ~arl_en;
  assign rx_bit  = rx_pos | rx_neg;

  // Only one code is watched at a time: the exit code while looped
  assign act_code = auto_looped ? {dn_hi, dn_lo} : {up_hi, up_lo};
  assign act_len  = auto_looped ? dn_len : up_len;

  rlb_pattern_det #(
    .WIN(WIN), .CW(CW), .MAX_ERR(MAX_ERR), .LEN_W(LEN_W)
  ) u_det (
    .clk(clk), .rst_n(rst_n), .en(arl_en),
    .bit_stb(rx_stb), .bit_in(rx_bit),
    .code(act_code), .len_raw(act_len),
    .match(det_match), .full(det_full)
  );

  rlb_qual_fsm #(
    .QUAL_TICKS(QUAL_TICKS), .CNT_W(CNT_W)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .en(arl_en), .tick(tick),
    .match(det_match), .state(fsm_state), .cnt(qual_cnt),
    .looped(auto_looped)
  );

  assign arl_stat = auto_looped;
  assign rlb_sel  = auto_looped | man_rlb;

  rlb_tx_mux #(.RAILS(2)) u_mux (
    .sel(rlb_sel),
    .rx_rails({rx_pos, rx_neg}),
    .tx_rails({tx_pos_i, tx_neg_i}),
    .line_rails(line_rails)
  );

  assign tx_pos_o = line_rails[1];
  assign tx_neg_o = line_rails[0];
  assign rxo_pos  = rx_pos;
  assign rxo_neg  = rx_neg;

endmodule

// File: rtl/rlb_auto_ctrl_chk.sv
`timescale 1ns/1ps
module rlb_auto_ctrl_chk #(
  parameter int QUAL_TICKS = 5000,
  parameter int CNT_W      = 13
) (
  input logic             clk,
  input logic             rst_n,
  input logic             arl_en,
  input logic             man_rlb,
  input logic             tick,
  input logic             rx_pos,
  input logic             rx_neg,
  input logic             tx_pos_o,
  input logic             tx_neg_o,
  input logic             rlb_sel,
  input logic             arl_stat,
  input logic             en_fall,
  input logic             det_match,
  input logic             det_full,
  input logic [CNT_W-1:0] qual_cnt
);

  AST_NO_MATCH_UNFILLED: assert property (@(posedge clk) disable iff (!rst_n)
    !det_full |-> !det_match); // R1

  AST_ENTRY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arl_stat) |-> ($past(tick) && $past(det_match) && $past(arl_en))); // R2

  AST_CNT_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    int'(qual_cnt) < QUAL_TICKS); // R3

  AST_EXIT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(arl_stat) |-> ($past(!arl_en) || ($past(tick) && $past(det_match)))); // R4

  AST_EN_FALL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    en_fall |=> !arl_stat); // R6

  AST_MANUAL_FORCES: assert property (@(posedge clk) disable iff (!rst_n)
    man_rlb |-> rlb_sel); // R7

  AST_LOOP_RAILS: assert property (@(posedge clk) disable iff (!rst_n)
    rlb_sel |-> (tx_pos_o == rx_pos && tx_neg_o == rx_neg)); // R8

endmodule

bind rlb_auto_ctrl rlb_auto_ctrl_chk #(
  .QUAL_TICKS(QUAL_TICKS), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .arl_en(arl_en), .man_rlb(man_rlb),
  .tick(tick), .rx_pos(rx_pos), .rx_neg(rx_neg),
  .tx_pos_o(tx_pos_o), .tx_neg_o(tx_neg_o), .rlb_sel(rlb_sel),
  .arl_stat(arl_stat), .en_fall(en_fall), .det_match(det_match),
  .det_full(det_full), .qual_cnt(qual_cnt)
);

// File: tb/test_rlb_auto_ctrl.sv
`timescale 1ns/1ps
module test_rlb_auto_ctrl;

  localparam int QT = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       arl_en = 1'b0, man_rlb = 1'b0, tick = 1'b0;
  logic       rx_stb = 1'b0, rx_pos = 1'b0, rx_neg = 1'b0;
  logic [7:0] up_hi = '0, up_lo = '0, dn_hi = '0, dn_lo = '0;
  logic [4:0] up_len = '0, dn_len = '0;
  logic       tx_pos_i = 1'b0, tx_neg_i = 1'b0;
  logic       tx_pos_o, tx_neg_o, rxo_pos, rxo_neg, rlb_sel, arl_stat;

  int n_chk = 0;
  int n_err = 0;
  int cyc   = 0;
  bit pol   = 1'b0;

  // reference model state
  bit [31:0] m_win   = '0;
  int        m_fill  = 0;
  int        m_state = 0; // 0 idle, 1 qualify up, 2 looped, 3 qualify down
  int        m_cnt   = 0;

  always #5 clk = ~clk;

  rlb_auto_ctrl #(.QUAL_TICKS(QT)) i_rlb_auto_ctrl (
    .clk(clk), .rst_n(rst_n), .arl_en(arl_en), .man_rlb(man_rlb), .tick(tick),
    .rx_stb(rx_stb), .rx_pos(rx_pos), .rx_neg(rx_neg),
    .up_hi(up_hi), .up_lo(up_lo), .up_len(up_len),
    .dn_hi(dn_hi), .dn_lo(dn_lo), .dn_len(dn_len),
    .tx_pos_i(tx_pos_i), .tx_neg_i(tx_neg_i),
    .tx_pos_o(tx_pos_o), .tx_neg_o(tx_neg_o),
    .rxo_pos(rxo_pos), .rxo_neg(rxo_neg),
    .rlb_sel(rlb_sel), .arl_stat(arl_stat)
  );

  function automatic int blen(input bit [4:0] l);
    return (l == 0 || l > 16) ? 16 : int'(l);
  endfunction

  // R1 R9: try every rotation of the repeated code, allow one wrong bit
  function automatic bit bmatch(input bit [31:0] w, input bit [15:0] c, input bit [4:0] lr);
    int L;
    L = blen(lr);
    for (int ph = 0; ph < L; ph++) begin
      int e;
      e = 0;
      for (int i = 0; i < 32; i++) begin
        int k;
        k = (ph + 32 * L - i) % L;
        if (w[i] != c[15-k]) e++;
      end
      if (e <= 1) return 1'b1;
    end
    return 1'b0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_win = '0; m_fill = 0; m_state = 0; m_cnt = 0;
    end else begin
      bit mt;
      if (m_state >= 2) mt = (m_fill == 32) && bmatch(m_win, {dn_hi, dn_lo}, dn_len);
      else              mt = (m_fill == 32) && bmatch(m_win, {up_hi, up_lo}, up_len);
      if (!arl_en) begin
        m_state = 0; m_cnt = 0;
      end else begin
        case (m_state)
          0, 2: if (mt) begin m_state = m_state + 1; m_cnt = 0; end
          default: begin
            if (!mt) begin
              m_state = m_state - 1; m_cnt = 0;
            end else if (tick) begin
              if (m_cnt == QT - 1) begin
                m_state = (m_state == 1) ? 2 : 0; m_cnt = 0;
              end else m_cnt++;
            end
          end
        endcase
      end
      if (rx_stb) m_win = {m_win[30:0], rx_pos | rx_neg};
      if (!arl_en) m_fill = 0;
      else if (rx_stb && m_fill < 32) m_fill++;
    end
  end

  task automatic chk(input string tag, input logic [1:0] act, input logic [1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    bit es;
    @(negedge clk);
    es = (m_state >= 2);
    chk("R2 R4 arl_stat vs model", {1'b0, arl_stat}, {1'b0, es});
    chk("R7 rlb_sel", {1'b0, rlb_sel}, {1'b0, es | man_rlb});
    chk("R8 tx rails", {tx_pos_o, tx_neg_o},
        (es | man_rlb) ? {rx_pos, rx_neg} : {tx_pos_i, tx_neg_i});
    chk("R8 rx passthrough", {rxo_pos, rxo_neg}, {rx_pos, rx_neg});
    tick = ((cyc % 16) == 0);
    cyc++;
    tx_pos_i = 1'($urandom);
    tx_neg_i = 1'($urandom);
  endtask

  task automatic send_bit(input bit b);
    rx_stb = 1'b1;
    if (b) begin pol = ~pol; rx_pos = pol; rx_neg = ~pol; end
    else   begin rx_pos = 1'b0; rx_neg = 1'b0; end
    step();
    rx_stb = 1'b0;
    rx_pos = 1'($urandom);
    rx_neg = 1'($urandom);
    step();
  endtask

  // kind: 0 loop-up code, 1 loop-down code, 2 zeros, 3 random bits
  task automatic send_seq(input int kind, input int n, input int flip);
    bit [15:0] c;
    int L, k;
    c = (kind == 1) ? {dn_hi, dn_lo} : {up_hi, up_lo};
    L = blen((kind == 1) ? dn_len : up_len);
    k = 0;
    for (int j = 0; j < n; j++) begin
      bit b;
      case (kind)
        0, 1:    b = c[15-k];
        2:       b = 1'b0;
        default: b = 1'($urandom);
      endcase
      if (flip > 0 && (j % flip) == flip - 1) b = ~b;
      send_bit(b);
      k = (k + 1) % L;
    end
  endtask

  initial begin
    #2_000_000;
    n_err++; n_chk++;
    $display("FAIL R2 watchdog act=running exp=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h1d2c_3b4a));
    repeat (4) step();
    chk("R6 reset arl_stat", {1'b0, arl_stat}, 2'd0);
    chk("R7 reset rlb_sel", {1'b0, rlb_sel}, 2'd0);
    rst_n = 1'b1;
    up_hi = 8'b1100_1010; up_lo = 8'h00; up_len = 5'd7;
    dn_hi = 8'hF0;        dn_lo = 8'hA3; dn_len = 5'd16;
    arl_en = 1'b1;
    step();

    send_seq(0, 200, 0);
    chk("R2 loop-up held enters loopback", {1'b0, arl_stat}, 2'd1);
    send_seq(0, 200, 0);
    chk("R5 loop-up ignored while looped", {1'b0, arl_stat}, 2'd1);
    send_seq(1, 200, 0);
    chk("R4 loop-down held leaves loopback", {1'b0, arl_stat}, 2'd0);
    send_seq(1, 200, 0);
    chk("R5 loop-down ignored while idle", {1'b0, arl_stat}, 2'd0);

    send_seq(0, 48, 0);
    send_seq(2, 16, 0);
    send_seq(0, 40, 0);
    chk("R3 break restarts qualification", {1'b0, arl_stat}, 2'd0);
    send_seq(0, 80, 0);
    chk("R3 requalified after break", {1'b0, arl_stat}, 2'd1);

    arl_en = 1'b0;
    step(); step();
    chk("R6 enable low clears status", {1'b0, arl_stat}, 2'd0);
    send_seq(0, 200, 0);
    chk("R6 no loopback while disabled", {1'b0, arl_stat}, 2'd0);
    arl_en = 1'b1;

    send_seq(0, 200, 10);
    chk("R9 three errors per window rejected", {1'b0, arl_stat}, 2'd0);
    send_seq(0, 200, 40);
    chk("R9 one error per window tolerated", {1'b0, arl_stat}, 2'd1);
    send_seq(1, 200, 0);
    chk("R4 exit after tolerance test", {1'b0, arl_stat}, 2'd0);

    man_rlb = 1'b1;
    step(); step();
    chk("R7 manual forces select", {1'b0, rlb_sel}, 2'd1);
    chk("R8 manual loop rails", {tx_pos_o, tx_neg_o}, {rx_pos, rx_neg});
    man_rlb = 1'b0;
    step();

    up_hi = 8'h8E; up_lo = 8'h31; up_len = 5'd0;
    send_seq(0, 200, 0);
    chk("R1 length 0 means 16", {1'b0, arl_stat}, 2'd1);
    dn_hi = 8'h4D; dn_lo = 8'hC2; dn_len = 5'd20;
    send_seq(1, 200, 0);
    chk("R1 length 20 means 16", {1'b0, arl_stat}, 2'd0);

    for (int s = 0; s < 60; s++) begin
      if (s % 6 == 0) begin
        up_hi = 8'($urandom); up_lo = 8'($urandom); up_len = 5'($urandom_range(0, 20));
        dn_hi = 8'($urandom); dn_lo = 8'($urandom); dn_len = 5'($urandom_range(0, 20));
      end
      man_rlb = (($urandom % 8) == 0);
      if (($urandom % 10) == 0) begin
        arl_en = 1'b0;
        repeat ($urandom_range(1, 4)) step();
        arl_en = 1'b1;
      end
      send_seq(int'($urandom % 4), int'($urandom_range(8, 120)),
               (($urandom % 3) == 0) ? int'($urandom_range(5, 40)) : 0);
    end
    man_rlb = 1'b0;
    step(); step();

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule